// File: doc/BRIEF.md
# AES Byte Substitution Unit

This block maps one byte per clock through the AES substitution function, in either direction. A direction input picks the forward mapping (field inversion followed by the affine step) or the reverse mapping (inverse affine step followed by field inversion). No 256-entry table is stored. The result is computed with GF(2^8) arithmetic modulo x^8 + x^4 + x^3 + x + 1, and one inverter serves both directions. The two affine steps sit on either side of it.

The result is captured in an output register and appears one clock after the byte is presented. A clock-enable input lets the register update only when work is present; on idle cycles the register holds its value, as a gated clock would. An optional mask input complements the substituted byte before it is captured. A cipher datapath uses the block as its byte substitution slice; the surrounding row, column and key steps live elsewhere.

Top module: `sbox_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `dout` to 0x00 and `outValid` to 0 at the next rising edge, whatever `en` is.
- R2: With `mode`=0 and `maskEn`=0, `dout` equals the field inverse of `din` passed through the forward affine step (constant 0x63), so 0x00 gives 0x63 and 0x53 gives 0xED.
- R3: With `mode`=1 and `maskEn`=0, `dout` equals the field inverse of the reverse affine step (constant 0x05) of `din`, so that reverse(forward(x)) = x for all 256 byte values.
- R4: The field inverse of 0x00 is taken as 0x00, so the reverse mapping of 0x63 is 0x00.
- R5: The result for a byte accepted at a rising edge with `en`=1 is on `dout` directly after that edge, one cycle after `din` was presented.
- R6: While `en`=0, `dout` keeps its previous value whatever `din`, `mode` and `maskEn` do.
- R7: `outValid` equals the value `en` had at the previous rising edge (0 after reset).
- R8: With `maskEn`=1, `dout` equals the unmasked result for the same `din` and `mode` XOR 0xFF.
- R9: `mode` and `maskEn` are sampled per byte, so consecutive bytes may switch direction or masking with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; accepts `din` this edge |
| mode | input | 1 | 0 = forward mapping, 1 = reverse mapping |
| maskEn | input | 1 | 1 = complement the substituted byte |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Registered substituted byte |
| outValid | output | 1 | `en` delayed by one cycle |

## Verification
The hardest case to reach from the ports is a change of direction or masking on every cycle with no idle gap. A stale select or a wrong inverter input then only shows when the previous byte's settings leak into the next one. The stimulus sweeps all 256 values with forward and reverse requests interleaved back to back, and feeds each forward result straight back as the next reverse input. It then runs a seeded random mix of direction, mask and enable, including idle cycles that must leave the held byte untouched.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] REDUCE = 8'h1B;   // x^8 = x^4+x^3+x+1
  localparam logic [BYTE_W-1:0] FWD_ADD = 8'h63;
  localparam logic [BYTE_W-1:0] REV_ADD = 8'h05;

  typedef logic [BYTE_W-1:0] byte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic inverse;
    logic mask;
  } sboxStrobe_t;

  function automatic byte_t rotl(byte_t a, int n);
    return byte_t'((a << n) | (a >> (BYTE_W - n)));
  endfunction

  function automatic byte_t xtime(byte_t a);
    return a[BYTE_W-1] ? ((a << 1) ^ REDUCE) : (a << 1);
  endfunction

  function automatic byte_t gfMul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t sh = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  function automatic byte_t gfSq(byte_t a);
    return gfMul(a, a);
  endfunction

  // a^254 by an addition chain; 0 maps to 0
  function automatic byte_t gfInv(byte_t a);
    byte_t p3, p7, p15, p31, p63, p127;
    p3   = gfMul(gfSq(a), a);
    p7   = gfMul(gfSq(p3), a);
    p15  = gfMul(gfSq(p7), a);
    p31  = gfMul(gfSq(p15), a);
    p63  = gfMul(gfSq(p31), a);
    p127 = gfMul(gfSq(p63), a);
    return gfSq(p127);
  endfunction

  function automatic byte_t affineFwd(byte_t a);
    return a ^ rotl(a, 1) ^ rotl(a, 2) ^ rotl(a, 3) ^ rotl(a, 4) ^ FWD_ADD;
  endfunction

  function automatic byte_t affineRev(byte_t a);
    return rotl(a, 1) ^ rotl(a, 3) ^ rotl(a, 6) ^ REV_ADD;
  endfunction

endpackage

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        mode,
  input  logic        maskEn,
  output sboxStrobe_t stb,
  output logic        outValid
);

  always_comb begin
    stb.clear   = rst;
    stb.load    = en;
    stb.inverse = mode;
    stb.mask    = maskEn;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= en;
  end

endmodule

// File: rtl/sbox_dp.sv
module sbox_dp
  import sbox_pkg::*;
(
  input  logic        clk,
  input  sboxStrobe_t stb,
  input  byte_t       din,
  output byte_t       dout
);

  byte_t preInv, invOut, postInv, subOut;

  always_comb begin
    // reverse: affine undo before the shared inverter
    preInv  = stb.inverse ? affineRev(din) : din;
    invOut  = gfInv(preInv);
    // forward: affine after the shared inverter
    postInv = stb.inverse ? invOut : affineFwd(invOut);
    subOut  = postInv ^ {BYTE_W{stb.mask}};
  end

  always_ff @(posedge clk) begin
    if (stb.clear)     dout <= '0;
    else if (stb.load) dout <= subOut;
  end

endmodule

// File: rtl/sbox_unit.sv
module sbox_unit
  import sbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       mode,
  input  logic       maskEn,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       outValid
);

  sboxStrobe_t stb;

  sbox_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .maskEn(maskEn),
    .stb(stb), .outValid(outValid)
  );

  sbox_dp u_dp (
    .clk(clk), .stb(stb), .din(din), .dout(dout)
  );

endmodule

// File: rtl/sbox_unit_chk.sv
module sbox_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       mode,
  input logic       maskEn,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       outValid
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dout == 8'h00 && !outValid));

  // R6
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));

  // R7
  a_r7_valid_follows_en: assert property (@(posedge clk) disable iff (rst)
    en |=> outValid);

  a_r7_valid_low_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> !outValid);

  // R2, R5
  a_r2_fwd_zero: assert property (@(posedge clk) disable iff (rst)
    (en && !mode && !maskEn && din == 8'h00) |=> dout == 8'h63);

  // R4
  a_r4_rev_of_63: assert property (@(posedge clk) disable iff (rst)
    (en && mode && !maskEn && din == 8'h63) |=> dout == 8'h00);

  // R8
  a_r8_masked_fwd_zero: assert property (@(posedge clk) disable iff (rst)
    (en && !mode && maskEn && din == 8'h00) |=> dout == 8'h9C);

endmodule

bind sbox_unit sbox_unit_chk u_chk (.*);

// File: tb/sbox_unit_tb.sv
module sbox_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic       maskEn = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       outValid;

  int total = 0;
  int bad = 0;
  logic [7:0] fwdTab [256];
  logic [7:0] revTab [256];
  logic [7:0] model;

  always #10 clk = ~clk;   // 50 MHz

  sbox_unit u_dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .maskEn(maskEn),
    .din(din), .dout(dout), .outValid(outValid)
  );

  function automatic logic [7:0] bMul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] bInv(logic [7:0] a);
    logic [7:0] r = 8'h00;
    for (int b = 1; b < 256; b++) if (bMul(a, 8'(b)) == 8'h01) r = 8'(b);
    return r;
  endfunction

  function automatic logic [7:0] bFwd(logic [7:0] x);
    logic [7:0] a = bInv(x);
    logic [7:0] r;
    logic [7:0] c = 8'h63;
    for (int i = 0; i < 8; i++)
      r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ c[i];
    return r;
  endfunction

  function automatic logic [7:0] expect_of(logic m, logic k, logic [7:0] x);
    logic [7:0] r = m ? revTab[x] : fwdTab[x];
    return k ? ~r : r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(logic e, logic m, logic k, logic [7:0] x);
    @(negedge clk);
    en = e; mode = m; maskEn = k; din = x;
    @(posedge clk);
    #1;
    if (e) model = expect_of(m, k, x);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] f;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) fwdTab[i] = bFwd(8'(i));
    for (int i = 0; i < 256; i++) revTab[fwdTab[i]] = 8'(i);
    model = 8'h00;

    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 dout after reset", dout, 8'h00);
    check("R1 valid after reset", {7'b0, outValid}, 8'h00);
    @(negedge clk); rst = 1'b0;

    // R2 R4 R5 R7 directed corners
    apply(1, 0, 0, 8'h00);
    check("R2 R4 R5 fwd(00)", dout, 8'h63);
    check("R7 valid one cycle after en", {7'b0, outValid}, 8'h01);
    apply(1, 0, 0, 8'h53);
    check("R2 fwd(53)", dout, 8'hED);
    apply(1, 1, 0, 8'h63);
    check("R4 rev(63)", dout, 8'h00);
    apply(1, 1, 0, 8'hED);
    check("R3 rev(ED)", dout, 8'h53);
    apply(1, 0, 1, 8'h00);
    check("R8 masked fwd(00)", dout, 8'h9C);

    // R2 R3 R9 full sweep, direction switching each cycle
    for (int x = 0; x < 256; x++) begin
      apply(1, 0, 0, 8'(x));
      check("R2 fwd sweep", dout, fwdTab[x]);
      f = dout;
      apply(1, 1, 0, f);
      check("R3 R9 rev(fwd(x))", dout, 8'(x));
    end

    // R6 R7 idle holds
    apply(1, 0, 0, 8'h11);
    for (int i = 0; i < 4; i++) begin
      apply(0, i[0], i[1], 8'($urandom));
      check("R6 idle hold", dout, fwdTab[8'h11]);
      check("R7 valid low when idle", {7'b0, outValid}, 8'h00);
    end

    // R8 mask against unmasked for both modes
    for (int i = 0; i < 64; i++) begin
      logic [7:0] x = 8'($urandom);
      logic m = 1'($urandom);
      apply(1, m, 0, x);
      f = dout;
      apply(1, m, 1, x);
      check("R8 masked equals unmasked xor FF", dout, f ^ 8'hFF);
    end

    // R9 R6 random mix
    for (int i = 0; i < 300; i++) begin
      logic e = ($urandom % 4) != 0;
      apply(e, 1'($urandom), 1'($urandom), 8'($urandom));
      check("R9 random mix", dout, model);
      check("R7 random valid", {7'b0, outValid}, {7'b0, e});
    end

    // R1 reset overrides enable
    @(negedge clk); rst = 1'b1; en = 1'b1; din = 8'h53; mode = 1'b0;
    @(posedge clk); #1;
    check("R1 reset overrides en", dout, 8'h00);
    check("R1 reset clears valid", {7'b0, outValid}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule